// File: doc/BRIEF.md
# Rotate-and-Merge Shifter Unit

This block is the execution stage of a shift instruction that deposits a rotated copy of a source word into selected bit positions of a destination register. The source is rotated circularly left or right. A composite mask is then formed from two parts: a low-bits mask whose width comes from a 5-bit end field, optionally complemented, and a low-bits mask whose width depends on the rotate amount and the direction. Bits of the rotated source that fall inside the composite mask replace the matching destination bits; every other bit keeps the old destination value.

The issuing logic presents the source word, the current destination value, the decoded fields and a valid strobe in one cycle. On the next clock edge the merged word appears on the result register, together with a write enable that is held low when the destination index is zero, so that register zero is never written. The data width must be a power of two; the amount and end-field widths are derived from it.

Top module: `rmsh_unit`

## Requirements
- R1: While reset is asserted, and on the first edges after it, `res_word` is 0 and `res_we` is 0.
- R2: `dir_right` = 1 rotates the source circularly right by `rot_amt` (result bit i takes source bit (i+amt) mod W); `dir_right` = 0 rotates it left (bit i takes source bit (i-amt) mod W).
- R3: The end mask sets the low n bits, where n is the value of `end_fld`; an `end_fld` of 0 stands for the full width W, so the end mask is all ones.
- R4: With `inv_end` = 1 the end mask is complemented before it is combined.
- R5: The shift mask sets the low `rot_amt` bits for a left rotate and the low W-`rot_amt` bits for a right rotate; a right rotate by 0 therefore gives an all-ones shift mask.
- R6: The composite mask is end mask AND shift mask, and the result is (rotated source AND composite) OR (old destination AND NOT composite); bits outside the composite mask equal the old destination.
- R7: A strobe with `dst_idx` = 0 leaves `res_we` at 0 in the following cycle.
- R8: A strobe with a nonzero `dst_idx` drives `res_we` to 1 and the merged value onto `res_word` one clock after the strobe edge.
- R9: In a cycle with no strobe, `res_we` goes to 0 at the next edge and `res_word` keeps its value.
- R10: A left rotate by 0 yields an empty composite mask, so the result equals the old destination whatever the other fields are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe for this cycle |
| src_word | input | DATA_W | Word to be rotated |
| dst_old | input | DATA_W | Current destination register value |
| rot_amt | input | log2(DATA_W) | Rotate amount |
| end_fld | input | log2(DATA_W) | End-mask width, 0 meaning full width |
| dir_right | input | 1 | 1 rotate right, 0 rotate left |
| inv_end | input | 1 | Complement the end mask |
| dst_idx | input | IDX_W | Destination register index |
| res_word | output | DATA_W | Registered merged result |
| res_we | output | 1 | Registered write enable for the destination |

## Verification
The bench builds the unit with its default parameters, DATA_W = 32 and IDX_W = 5, which makes the whole field space of five-bit amount and five-bit end field small enough to sweep: every combination of rotate amount, end field, direction and invert flag is applied once with fresh random source and destination words. That sweep reaches the edge points named in the requirements, the end field of 0, the right rotate by 0 that opens the full shift mask and the left rotate by 0 that closes it. Directed scenarios add hand-worked values, the zero-index write suppression and idle-cycle holding.

// File: rtl/rmsh_pkg.sv
package rmsh_pkg;
  parameter int unsigned RMSH_DW  = 32;
  parameter int unsigned RMSH_IDX = 5;

  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/rmsh_rotator.sv
module rmsh_rotator #(
  parameter int unsigned DATA_W = rmsh_pkg::RMSH_DW,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  rmsh_pkg::rot_dir_e dir,
  output logic [DATA_W-1:0] rotated
);
  function automatic logic [DATA_W-1:0] rot_r(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] a);
    logic [2*DATA_W-1:0] t;
    t = {v, v} >> a;
    return t[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] rot_l(input logic [DATA_W-1:0] v,
                                              input logic [AMT_W-1:0] a);
    logic [2*DATA_W-1:0] t;
    t = {v, v} << a;
    return t[2*DATA_W-1:DATA_W];
  endfunction

  always_comb begin
    if (dir == rmsh_pkg::ROT_RIGHT) rotated = rot_r(src, amt);
    else                            rotated = rot_l(src, amt);
  end
endmodule

// File: rtl/rmsh_mask_gen.sv
module rmsh_mask_gen #(
  parameter int unsigned DATA_W = rmsh_pkg::RMSH_DW,
  localparam int unsigned AMT_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = AMT_W + 1
) (
  input  logic [AMT_W-1:0]  amt,
  input  logic [AMT_W-1:0]  end_fld,
  input  rmsh_pkg::rot_dir_e dir,
  input  logic              inv_end,
  output logic [DATA_W-1:0] end_mask,
  output logic [DATA_W-1:0] shift_mask,
  output logic [DATA_W-1:0] comp_mask
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  function automatic logic [DATA_W-1:0] low_ones(input logic [CNT_W-1:0] n);
    logic [DATA_W:0] t;
    t = ({{DATA_W{1'b0}}, 1'b1} << n) - 1'b1;
    return t[DATA_W-1:0];
  endfunction

  logic [CNT_W-1:0] end_cnt;
  logic [CNT_W-1:0] shift_cnt;
  logic [DATA_W-1:0] end_raw;

  always_comb begin
    end_cnt   = (end_fld == '0) ? FULL_CNT : {1'b0, end_fld};
    shift_cnt = (dir == rmsh_pkg::ROT_RIGHT) ? (FULL_CNT - {1'b0, amt})
                                             : {1'b0, amt};
    end_raw    = low_ones(end_cnt);
    end_mask   = inv_end ? ~end_raw : end_raw;
    shift_mask = low_ones(shift_cnt);
    comp_mask  = end_mask & shift_mask;
  end
endmodule

// File: rtl/rmsh_merge.sv
module rmsh_merge #(
  parameter int unsigned DATA_W = rmsh_pkg::RMSH_DW
) (
  input  logic [DATA_W-1:0] rotated,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] sel_mask,
  output logic [DATA_W-1:0] merged
);
  function automatic logic [DATA_W-1:0] blend(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic [DATA_W-1:0] m);
    return (a & m) | (b & ~m);
  endfunction

  assign merged = blend(rotated, old_val, sel_mask);
endmodule

// File: rtl/rmsh_unit.sv
module rmsh_unit #(
  parameter int unsigned DATA_W = rmsh_pkg::RMSH_DW,
  parameter int unsigned IDX_W  = rmsh_pkg::RMSH_IDX,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [AMT_W-1:0]  rot_amt,
  input  logic [AMT_W-1:0]  end_fld,
  input  logic              dir_right,
  input  logic              inv_end,
  input  logic [IDX_W-1:0]  dst_idx,
  output logic [DATA_W-1:0] res_word,
  output logic              res_we
);
  rmsh_pkg::rot_dir_e dir;
  logic [DATA_W-1:0]  rotated;
  logic [DATA_W-1:0]  end_mask;
  logic [DATA_W-1:0]  shift_mask;
  logic [DATA_W-1:0]  comp_mask;
  logic [DATA_W-1:0]  merged;
  logic               dst_live;

  assign dir      = dir_right ? rmsh_pkg::ROT_RIGHT : rmsh_pkg::ROT_LEFT;
  assign dst_live = (dst_idx != '0);

  rmsh_rotator #(.DATA_W(DATA_W)) u_rot (
    .src     (src_word),
    .amt     (rot_amt),
    .dir     (dir),
    .rotated (rotated)
  );

  rmsh_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .amt        (rot_amt),
    .end_fld    (end_fld),
    .dir        (dir),
    .inv_end    (inv_end),
    .end_mask   (end_mask),
    .shift_mask (shift_mask),
    .comp_mask  (comp_mask)
  );

  rmsh_merge #(.DATA_W(DATA_W)) u_merge (
    .rotated  (rotated),
    .old_val  (dst_old),
    .sel_mask (comp_mask),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_word <= '0;
      res_we   <= 1'b0;
    end else begin
      res_we <= in_valid & dst_live;
      if (in_valid) res_word <= merged;
    end
  end
endmodule

// File: rtl/rmsh_unit_chk.sv
module rmsh_unit_chk #(
  parameter int unsigned DATA_W = rmsh_pkg::RMSH_DW,
  parameter int unsigned IDX_W  = rmsh_pkg::RMSH_IDX,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_old,
  input logic [AMT_W-1:0]  rot_amt,
  input logic              dir_right,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [DATA_W-1:0] comp_mask,
  input logic [DATA_W-1:0] res_word,
  input logic              res_we
);
  // R1: reset clears both outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (res_we == 1'b0 && res_word == '0));

  // R6: bits outside the composite mask come from the old destination
  a_r6_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((res_word ^ $past(dst_old)) & ~$past(comp_mask)) == '0));

  // R7: index zero never writes
  a_r7_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_idx == '0) |=> !res_we);

  // R8: live index writes next cycle
  a_r8_write_live: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_idx != '0) |=> res_we);

  // R9: idle cycle drops enable and holds the word
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_we && $stable(res_word)));

  // R10: left rotate by zero returns the old destination
  a_r10_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dir_right && rot_amt == '0) |=> (res_word == $past(dst_old)));
endmodule

bind rmsh_unit rmsh_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .dst_old   (dst_old),
  .rot_amt   (rot_amt),
  .dir_right (dir_right),
  .dst_idx   (dst_idx),
  .comp_mask (comp_mask),
  .res_word  (res_word),
  .res_we    (res_we)
);

// File: tb/tb_rmsh_unit.sv
module tb_rmsh_unit;
  localparam int W  = 32;
  localparam int AW = 5;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  src_word = '0;
  logic [W-1:0]  dst_old = '0;
  logic [AW-1:0] rot_amt = '0;
  logic [AW-1:0] end_fld = '0;
  logic          dir_right = 1'b0;
  logic          inv_end = 1'b0;
  logic [IW-1:0] dst_idx = '0;
  logic [W-1:0]  res_word;
  logic          res_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rmsh_unit #(.DATA_W(W), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .dst_old(dst_old), .rot_amt(rot_amt), .end_fld(end_fld),
    .dir_right(dir_right), .inv_end(inv_end), .dst_idx(dst_idx),
    .res_word(res_word), .res_we(res_we)
  );

  // Bit-by-bit model written from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] o,
                                         input int r, input int e, input bit rt, input bit iv);
    logic [W-1:0] rv, em, sm, m;
    int en, sn;
    en = (e == 0) ? W : e;
    sn = rt ? (W - r) : r;
    for (int i = 0; i < W; i++) begin
      rv[i] = rt ? s[(i + r) % W] : s[(i - r + W) % W];
      em[i] = (i < en);
      sm[i] = (i < sn);
    end
    if (iv) em = ~em;
    m = em & sm;
    return (rv & m) | (o & ~m);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one strobe, wait for the capture edge, sample after it
  task automatic issue(input logic [W-1:0] s, input logic [W-1:0] o, input int r,
                       input int e, input bit rt, input bit iv, input int idx);
    @(negedge clk);
    src_word = s; dst_old = o; rot_amt = AW'(r); end_fld = AW'(e);
    dir_right = rt; inv_end = iv; dst_idx = IW'(idx); in_valid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    src_word = ~src_word; dst_old = ~dst_old;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 word", res_word, '0);
    check("R1 we", W'(res_we), '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 word after release", res_word, '0);
    check("R1 we after release", W'(res_we), '0);
  endtask

  task automatic t_directed();
    issue(32'h8000_0001, 32'hFFFF_FFFF, 4, 0, 1'b1, 1'b0, 3);
    check("R2 R5 right rotate", res_word, 32'hF800_0000);
    check("R8 we", W'(res_we), 1);
    issue(32'h8000_0001, 32'hFFFF_FFFF, 4, 0, 1'b0, 1'b0, 3);
    check("R2 R5 left rotate", res_word, 32'hFFFF_FFF8);
    issue(32'hFFFF_FFFF, 32'h0000_0000, 8, 16, 1'b1, 1'b1, 7);
    check("R3 R4 inverted end", res_word, 32'h00FF_0000);
    issue(32'hFFFF_FFFF, 32'h0000_0000, 8, 16, 1'b1, 1'b0, 7);
    check("R3 plain end", res_word, 32'h0000_FFFF);
    issue(32'hCAFE_BABE, 32'h1234_5678, 0, 0, 1'b0, 1'b1, 9);
    check("R10 left by zero", res_word, 32'h1234_5678);
    issue(32'hCAFE_BABE, 32'h1234_5678, 0, 0, 1'b1, 1'b0, 9);
    check("R5 right by zero full", res_word, 32'hCAFE_BABE);
  endtask

  task automatic t_zero_dst();
    issue(32'hA5A5_A5A5, 32'h0, 3, 0, 1'b1, 1'b0, 1);
    check("R8 we live", W'(res_we), 1);
    issue(32'hA5A5_A5A5, 32'h0, 3, 0, 1'b1, 1'b0, 0);
    check("R7 we zero index", W'(res_we), 0);
    check("R7 word", res_word, model(32'hA5A5_A5A5, 32'h0, 3, 0, 1'b1, 1'b0));
  endtask

  task automatic t_idle();
    logic [W-1:0] held;
    issue(32'h0F0F_1234, 32'hFFFF_0000, 12, 20, 1'b0, 1'b0, 4);
    held = res_word;
    idle_cycle();
    check("R9 we drops", W'(res_we), 0);
    check("R9 word held", res_word, held);
    idle_cycle();
    check("R9 word held again", res_word, held);
  endtask

  task automatic t_sweep();
    for (int r = 0; r < W; r++)
      for (int e = 0; e < W; e++)
        for (int d = 0; d < 2; d++)
          for (int v = 0; v < 2; v++) begin
            logic [W-1:0] s, o;
            s = $urandom; o = $urandom;
            issue(s, o, r, e, d[0], v[0], 1 + (r % 31));
            check("R6 sweep merge", res_word, model(s, o, r, e, d[0], v[0]));
          end
  endtask

  initial begin
    t_reset();
    t_directed();
    t_zero_dst();
    t_idle();
    t_sweep();
    idle_cycle();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule